// File: doc/BRIEF.md
# Dual-Window Signature Recorder

This block watches a small group of interface signals and folds their values, cycle by cycle, into compact signatures. After a failure, the signatures can be read out and compared against a model of the surrounding logic. Two signature registers run side by side from the same input vector. A shared cycle counter returns each register to its starting value on a staggered schedule, half a period apart. At any later moment, one of the two registers therefore holds a compressed record of at least one and at most two window lengths of recent history.

A capture request freezes both registers and the counter on the clock edge where it is seen. The values then stay fixed until the next global reset, so they can be read out in peace. The counter value tells which register holds the longer record and how many cycles that record spans.

Top module: `sigrec_dual`

## Requirements
- R1: On every active cycle each register shifts up by one bit. Bit 0 takes the XOR of the register bits selected by the tap mask, and input bit j is XORed into bit j of the shifted value. With the default parameters (4 inputs, 4 bits per input, signature width 16), the tap mask is 16'hB400, which selects bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1).
- R2: The signature width equals inputs times bits-per-input. The starting value of both registers has only bit 0 set. From the starting value, one cycle with inputs 0 gives 16'h0002, and a following cycle with inputs 4'b0001 gives 16'h0005.
- R3: A synchronous active-high reset loads both registers with the starting value, clears the counter to 0 and cancels any earlier freeze.
- R4: The counter is ceil(log2(2N)) bits wide. It advances by one on every active cycle and wraps from 2N-1 to 0, where N is the window parameter (default 16).
- R5: On the edge where the counter wraps to 0, register A is loaded with the starting value instead of shifting. On the edge where the counter moves from N-1 to N, register B is loaded with the starting value. The other register keeps absorbing the inputs on that edge.
- R6: Once N active cycles have passed since reset, consider the counter value c. If c >= N, register A holds the signature of exactly the last c sampled vectors. Otherwise, register B holds the signature of exactly the last c+N sampled vectors. In both cases the record spans between N and 2N-1 cycles.
- R7: On the edge where the capture request is high, neither register nor the counter changes. From then on, all three outputs hold their values regardless of inputs until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| sample_i | input | SIG_W | Sampled interface signals |
| capture_i | input | 1 | Freeze request |
| sig_a_o | output | SIG_W*BITS_PER_SIG | Signature of register A |
| sig_b_o | output | SIG_W*BITS_PER_SIG | Signature of register B |
| count_o | output | ceil(log2(2*WIN)) | Shared window counter |

## Verification
The assertions assume that reset is held for at least one clock edge before any check is meaningful. They also assume that the sampled vector and the capture request are stable around the rising edge. Past that, they take nothing about the data values, since any vector is legal input to the compressor. The bench drives all inputs on the falling edge and releases reset the same way. After the freeze it keeps changing the sampled vector, which tests that the frozen state ignores it.

// File: rtl/sigrec_pkg.sv
package sigrec_pkg;

  // Default feedback masks (bit i set: register bit i feeds bit 0).
  function automatic logic [63:0] default_taps(input int width);
    logic [63:0] m;
    case (width)
      6:       m = 64'h30;
      8:       m = 64'hB8;
      12:      m = 64'h829;
      16:      m = 64'hB400;
      24:      m = 64'hE10000;
      32:      m = 64'h80200003;
      default: m = (64'h1 << (width - 1)) | (64'h1 << (width - 2));
    endcase
    return m;
  endfunction

  // Starting value of every signature register.
  function automatic logic [63:0] seed_value();
    return 64'h1;
  endfunction

endpackage

// File: rtl/sigrec_misr_lane.sv
module sigrec_misr_lane #(
  parameter int           SIG_W  = 4,
  parameter int           K      = 16,
  parameter logic [K-1:0] TAPS   = '0,
  parameter logic [K-1:0] SEED   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             reload,
  input  logic [SIG_W-1:0] din,
  output logic [K-1:0]     sig
);

  logic [K-1:0] shifted;
  logic [K-1:0] injected;
  logic         feedback;

  always_comb begin
    feedback = ^(sig & TAPS);
    shifted  = {sig[K-2:0], feedback};
  end

  // Each input bit lands on its own register position.
  genvar gi;
  generate
    for (gi = 0; gi < K; gi++) begin : g_inj
      if (gi < SIG_W) begin : g_in
        assign injected[gi] = shifted[gi] ^ din[gi];
      end else begin : g_pass
        assign injected[gi] = shifted[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         sig <= SEED;
    else if (hold)   sig <= sig;
    else if (reload) sig <= SEED;
    else             sig <= injected;
  end

  // R7: frozen register does not move
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(sig));

  // R5: reload returns the register to its starting value
  a_r5_reload_seed: assert property (@(posedge clk) disable iff (rst)
    (reload && !hold) |=> (sig == SEED));

  // R3: first cycle after reset shows the starting value
  a_r3_reset_seed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sig == SEED));

endmodule

// File: rtl/sigrec_window_sched.sv
module sigrec_window_sched #(
  parameter int WIN = 16,
  parameter int CW  = $clog2(2 * WIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  output logic [CW-1:0] cnt,
  output logic          reload_a,
  output logic          reload_b
);

  localparam logic [CW-1:0] LAST = CW'(2 * WIN - 1);
  localparam logic [CW-1:0] MID  = CW'(WIN - 1);

  logic at_last;
  logic at_mid;

  always_comb begin
    at_last  = (cnt == LAST);
    at_mid   = (cnt == MID);
    reload_a = at_last && !hold;
    reload_b = at_mid  && !hold;
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (hold)    cnt <= cnt;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R4: counter never leaves 0..2N-1
  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R4: counter steps by one and wraps
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!hold && !$past(rst)) |=> ($past(cnt) == LAST) ? (cnt == '0) : (cnt == $past(cnt) + 1'b1));

  // R5: the two reloads are never on the same edge
  a_r5_one_reload: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reload_a, reload_b}));

  // R3: counter cleared by reset
  a_r3_count_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0));

endmodule

// File: rtl/sigrec_freeze_ctl.sv
module sigrec_freeze_ctl (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  output logic hold
);

  logic frozen_q;

  always_ff @(posedge clk) begin
    if (rst) frozen_q <= 1'b0;
    else     frozen_q <= frozen_q | capture;
  end

  assign hold = frozen_q | capture;

  // R7: once frozen, stays frozen until reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    frozen_q |=> frozen_q);

endmodule

// File: rtl/sigrec_dual.sv
module sigrec_dual
  import sigrec_pkg::*;
#(
  parameter int          SIG_W        = 4,
  parameter int          BITS_PER_SIG = 4,
  parameter int          WIN          = 16,
  parameter logic [63:0] TAP_MASK     = default_taps(SIG_W * BITS_PER_SIG)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [SIG_W-1:0]                       sample_i,
  input  logic                                   capture_i,
  output logic [SIG_W*BITS_PER_SIG-1:0]          sig_a_o,
  output logic [SIG_W*BITS_PER_SIG-1:0]          sig_b_o,
  output logic [$clog2(2*WIN)-1:0]               count_o
);

  localparam int           K     = SIG_W * BITS_PER_SIG;
  localparam int           CW    = $clog2(2 * WIN);
  localparam int           LANES = 2;
  localparam logic [K-1:0] TAPS  = TAP_MASK[K-1:0];
  localparam logic [63:0]  SEED64 = seed_value();
  localparam logic [K-1:0] SEED  = SEED64[K-1:0];

  generate
    if (K > 64) begin : g_bad_width
      $error("signature width above 64 bits");
    end
    if (K <= $clog2(WIN)) begin : g_bad_window
      $error("signature width must exceed log2 of the window");
    end
  endgenerate

  logic             hold;
  logic [LANES-1:0] reload;
  logic [K-1:0]     sig [LANES];
  logic [CW-1:0]    cnt;

  sigrec_freeze_ctl u_freeze (
    .clk     (clk),
    .rst     (rst),
    .capture (capture_i),
    .hold    (hold)
  );

  sigrec_window_sched #(
    .WIN (WIN),
    .CW  (CW)
  ) u_sched (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .cnt      (cnt),
    .reload_a (reload[0]),
    .reload_b (reload[1])
  );

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_lane
      sigrec_misr_lane #(
        .SIG_W (SIG_W),
        .K     (K),
        .TAPS  (TAPS),
        .SEED  (SEED)
      ) u_lane (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .reload (reload[gl]),
        .din    (sample_i),
        .sig    (sig[gl])
      );
    end
  endgenerate

  assign sig_a_o = sig[0];
  assign sig_b_o = sig[1];
  assign count_o = cnt;

endmodule

// File: tb/sigrec_dual_bench.sv
module sigrec_dual_bench;

  localparam int M    = 4;
  localparam int K    = 16;
  localparam int N    = 16;
  localparam int CW   = 5;
  localparam logic [K-1:0] TAPS = 16'hB400;
  localparam logic [K-1:0] SEED = 16'h0001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [M-1:0]  din = '0;
  logic          cap = 1'b0;
  logic [K-1:0]  sig_a, sig_b;
  logic [CW-1:0] count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sigrec_dual u_sigrec_dual (
    .clk       (clk),
    .rst       (rst),
    .sample_i  (din),
    .capture_i (cap),
    .sig_a_o   (sig_a),
    .sig_b_o   (sig_b),
    .count_o   (count)
  );

  // Reference model built from the requirements.
  function automatic logic [K-1:0] step(input logic [K-1:0] s, input logic [M-1:0] d);
    logic [K-1:0] n;
    n = {s[K-2:0], ^(s & TAPS)};
    n[M-1:0] = n[M-1:0] ^ d;
    return n;
  endfunction

  logic [K-1:0] ma, mb;
  int           mc;
  bit           mf;
  int           active;
  logic [M-1:0] hist [64];
  int           hptr;

  always @(posedge clk) begin
    if (rst) begin
      ma = SEED; mb = SEED; mc = 0; mf = 0; active = 0;
    end else if (mf || cap) begin
      mf = 1;
    end else begin
      ma = (mc == 2*N-1) ? SEED : step(ma, din);
      mb = (mc == N-1)   ? SEED : step(mb, din);
      mc = (mc + 1) % (2*N);
      hist[hptr] = din;
      hptr = (hptr + 1) % 64;
      active++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp_all(input string tag);
    check(sig_a == ma, {tag, " R1 sig_a"}, sig_a, ma);
    check(sig_b == mb, {tag, " R1 sig_b"}, sig_b, mb);
    check(count == CW'(mc), {tag, " R4 count"}, count, mc);
  endtask

  // R6: replay the last span samples from the starting value
  task automatic check_window(input string tag);
    logic [K-1:0] s;
    int span;
    s = SEED;
    span = (mc >= N) ? mc : mc + N;
    for (int i = span; i >= 1; i--) s = step(s, hist[(hptr - i + 64) % 64]);
    check(span >= N && span < 2*N, {tag, " R6 span"}, span, N);
    if (mc >= N) check(sig_a == s, {tag, " R6 window A"}, sig_a, s);
    else         check(sig_b == s, {tag, " R6 window B"}, sig_b, s);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cap = 1'b0; din = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    tick();
    din = 4'h0;
    // reset released at previous edge; one active edge done with din=0
    check(sig_a == 16'h0002, "R2 first step A", sig_a, 16'h0002);
    check(sig_b == 16'h0002, "R2 first step B", sig_b, 16'h0002);
    din = 4'h1;
    tick();
    check(sig_a == 16'h0005, "R2 second step", sig_a, 16'h0005);
    check(count == 5'd2, "R4 count after two", count, 2);
    din = '0;
    do_reset();
    @(posedge clk); @(negedge clk);
    // first negedge after release: reset edge plus one active edge
    cmp_all("R3 reset model");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 120; i++) begin
      din = M'($urandom);
      tick();
      cmp_all("stream");
      if (mc == 0) check(sig_a == SEED, "R5 reload A", sig_a, SEED);
      if (mc == N) check(sig_b == SEED, "R5 reload B", sig_b, SEED);
      if (active >= N) check_window("stream");
    end
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 40; i++) begin
      din = (i % 2) ? 4'hF : 4'h0;
      tick();
      cmp_all("R1 alternating");
    end
    for (int i = 0; i < 40; i++) begin
      din = 4'hA;
      tick();
      cmp_all("R1 constant");
    end
  endtask

  task automatic t_freeze(input int lead);
    logic [K-1:0] fa, fb;
    logic [CW-1:0] fc;
    do_reset();
    for (int i = 0; i < lead; i++) begin
      din = M'($urandom);
      tick();
    end
    cap = 1'b1;
    din = M'($urandom);
    tick();
    cap = 1'b0;
    cmp_all("R7 freeze edge");
    if (active >= N) check_window("R7 frozen");
    fa = sig_a; fb = sig_b; fc = count;
    for (int i = 0; i < 3*N; i++) begin
      din = M'($urandom);
      tick();
    end
    check(sig_a == fa, "R7 hold A", sig_a, fa);
    check(sig_b == fb, "R7 hold B", sig_b, fb);
    check(count == fc, "R7 hold count", count, fc);
    do_reset();
    din = 4'h0;
    tick();
    check(count == 5'd1, "R3 reset clears freeze", count, 1);
    check(sig_a == 16'h0002, "R3 reset clears freeze sig", sig_a, 16'h0002);
  endtask

  initial begin
    hptr = 0;
    t_reset();
    t_stream();
    t_patterns();
    t_freeze(N + 3);
    t_freeze(2*N + 7);
    t_freeze(5);
    t_freeze(N - 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule